// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register-mapped mailbox through which a host processor passes commands to an embedded microcontroller. The host loads up to three 32-bit parameter words and a command word whose low byte is an opcode, then rings a doorbell. While the doorbell is up, the microcontroller sees a level interrupt and can read the command and parameters directly from dedicated output ports. When it has consumed the command it pulses a completion strobe, which drops the doorbell. The host polls the same doorbell bit both to learn that the controller is ready for a new command and to learn that the last command has finished.

The microcontroller also owns a two-bit firmware readiness register that the host can read. Its legal values are absent, loaded but not yet initialised, and running. A status register mirrors a pin that tells the host the controller is held in reset. The block decodes whether the latched opcode belongs to the fixed command set and presents that as a flag to the controller. Parameter and command writes that arrive while a command is outstanding are refused, and a sticky error flag records that this happened.

Top module: `mbx_host_mailbox`

## Requirements
- R1: After reset the doorbell, the error flag, the command word, all parameter words and the firmware state read as zero, and `uc_irq` is low.
- R2: A host write to the control register (address 0) with data bit 0 set raises the doorbell (control bit 0). A control write with bit 0 clear leaves the doorbell unchanged.
- R3: A one-cycle `uc_done` pulse clears the doorbell on the next clock edge. If a ring write and `uc_done` arrive in the same cycle, the doorbell ends up set.
- R4: `uc_irq` is high exactly when the doorbell is set and `uc_in_reset` is low.
- R5: While the doorbell is clear, host writes to address 1 load the command word and writes to addresses 2, 3 and 4 load parameter words 0, 1 and 2. The command appears on `uc_cmd`, and parameter word k appears on `uc_param` bits [32k+31:32k]. Each register reads back at its address.
- R6: A host write to addresses 1 to 4 while the doorbell is set changes nothing and sets the sticky error flag (control bit 1). A control write with data bit 1 set clears that flag.
- R7: `uc_op_known` is high exactly when the low byte of the command word is one of 0x20, 0x21, 0x23, 0x31, 0x6A, 0x88, 0x89, 0x90 or 0x91.
- R8: The firmware state register (address 5, bits [1:0]) takes `uc_state_wdata` when `uc_state_we` is high and the value is 0, 1 or 2. A value of 3 is ignored, and so are host writes to address 5.
- R9: A read of the status register (address 6) returns `uc_in_reset` in bit 0 and zero elsewhere.
- R10: `host_rdata` is registered. It takes the addressed value on the clock edge where `host_rd` is high and holds it otherwise. Addresses 7 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host register word address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| uc_in_reset | input | 1 | Microcontroller is held in reset |
| uc_irq | output | 1 | Level interrupt to the microcontroller |
| uc_cmd | output | DATA_W | Command word |
| uc_op_known | output | 1 | Command opcode is in the recognised set |
| uc_param | output | NUM_PARAM*DATA_W | Parameter words, word 0 lowest |
| uc_done | input | 1 | Completion strobe, clears the doorbell |
| uc_state_we | input | 1 | Firmware state write enable |
| uc_state_wdata | input | 2 | Firmware state value |

## Verification
The bench targets the same-cycle collision of a ring write and a completion pulse. A design that gives priority to the clear would lose that command silently. It also targets writes of zero to the doorbell, which a naive read-modify-write design would let cancel an outstanding command. Command and parameter writes are made during an outstanding command, where a design without the guard would corrupt the words the controller is reading, and the sticky error flag is checked to survive unrelated control writes. An illegal firmware state value of 3 is written, and the interrupt is checked to be masked while the controller is held in reset even though the doorbell stays set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Register word offsets that do not depend on the parameter count
  localparam int OFS_CTRL   = 0;
  localparam int OFS_CMD    = 1;
  localparam int OFS_PARAM0 = 2;

  // Control register bit positions
  localparam int CTRL_BELL = 0;
  localparam int CTRL_ERR  = 1;

  typedef enum logic [1:0] {
    FW_ABSENT  = 2'd0,
    FW_LOADED  = 2'd1,
    FW_RUNNING = 2'd2
  } fw_state_e;

  localparam logic [7:0] OP_SR_ENTER   = 8'h20;
  localparam logic [7:0] OP_SR_LEAVE   = 8'h21;
  localparam logic [7:0] OP_SR_CONFIG  = 8'h23;
  localparam logic [7:0] OP_WAIT_LOOP  = 8'h31;
  localparam logic [7:0] OP_PWM_FRAC   = 8'h6A;
  localparam logic [7:0] OP_CTRL_INIT  = 8'h88;
  localparam logic [7:0] OP_IRAM_READY = 8'h89;
  localparam logic [7:0] OP_PHY_HOLD   = 8'h90;
  localparam logic [7:0] OP_PHY_FREE   = 8'h91;

  function automatic logic op_known(input logic [7:0] op);
    case (op)
      OP_SR_ENTER, OP_SR_LEAVE, OP_SR_CONFIG, OP_WAIT_LOOP, OP_PWM_FRAC,
      OP_CTRL_INIT, OP_IRAM_READY, OP_PHY_HOLD, OP_PHY_FREE: op_known = 1'b1;
      default: op_known = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mbx_doorbell.sv
module mbx_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic ring,
  input  logic done,
  input  logic err_clr,
  input  logic blocked,
  output logic bell_q,
  output logic err_q
);
  logic bell_d;
  logic err_d;

  // A ring in the same cycle as a completion keeps the bell up
  always_comb begin
    bell_d = bell_q;
    if (done) bell_d = 1'b0;
    if (ring) bell_d = 1'b1;
    err_d = err_q;
    if (err_clr) err_d = 1'b0;
    if (blocked) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bell_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      bell_q <= bell_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
  parameter int DATA_W    = 32,
  parameter int NUM_PARAM = 3,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_we,
  input  logic                        par_we,
  input  logic [ADDR_W-1:0]           par_sel,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           cmd_q,
  output logic [NUM_PARAM*DATA_W-1:0] par_q
);
  logic [DATA_W-1:0] cmd_d;

  always_comb cmd_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_we) cmd_q <= cmd_d;
  end

  for (genvar gi = 0; gi < NUM_PARAM; gi++) begin : g_par
    logic              en;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q;

    always_comb begin
      en = par_we && (par_sel == ADDR_W'(gi));
      d  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign par_q[gi*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/mbx_fw_state.sv
module mbx_fw_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] wdata,
  output logic [1:0] state_q
);
  import mbx_pkg::*;

  logic       en;
  logic [1:0] state_d;

  // Only the three defined readiness codes are accepted
  always_comb begin
    state_d = wdata;
    en      = we && (wdata <= FW_RUNNING);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= FW_ABSENT;
    else if (en) state_q <= state_d;
  end
endmodule

// File: rtl/mbx_host_mailbox.sv
module mbx_host_mailbox #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_PARAM = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           host_addr,
  input  logic                        host_wr,
  input  logic                        host_rd,
  input  logic [DATA_W-1:0]           host_wdata,
  output logic [DATA_W-1:0]           host_rdata,
  input  logic                        uc_in_reset,
  output logic                        uc_irq,
  output logic [DATA_W-1:0]           uc_cmd,
  output logic                        uc_op_known,
  output logic [NUM_PARAM*DATA_W-1:0] uc_param,
  input  logic                        uc_done,
  input  logic                        uc_state_we,
  input  logic [1:0]                  uc_state_wdata
);
  import mbx_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_PARAM0 = ADDR_W'(OFS_PARAM0);
  localparam logic [ADDR_W-1:0] A_FW     = ADDR_W'(OFS_PARAM0 + NUM_PARAM);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_PARAM0 + NUM_PARAM + 1);

  logic              wr_ctrl, wr_cmd, wr_par;
  logic              bell_q, err_q;
  logic [1:0]        fw_q;
  logic [DATA_W-1:0] rd_d;

  // Host write decode; command and parameter writes are guarded by the bell
  always_comb begin
    wr_ctrl = host_wr && (host_addr == A_CTRL);
    wr_cmd  = host_wr && (host_addr == A_CMD);
    wr_par  = host_wr && (host_addr >= A_PARAM0) && (host_addr < A_FW);
  end

  mbx_doorbell u_bell (
    .clk     (clk),
    .rst_n   (rst_n),
    .ring    (wr_ctrl && host_wdata[CTRL_BELL]),
    .done    (uc_done),
    .err_clr (wr_ctrl && host_wdata[CTRL_ERR]),
    .blocked ((wr_cmd || wr_par) && bell_q),
    .bell_q  (bell_q),
    .err_q   (err_q)
  );

  mbx_regfile #(
    .DATA_W    (DATA_W),
    .NUM_PARAM (NUM_PARAM),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_we  (wr_cmd && !bell_q),
    .par_we  (wr_par && !bell_q),
    .par_sel (host_addr - A_PARAM0),
    .wdata   (host_wdata),
    .cmd_q   (uc_cmd),
    .par_q   (uc_param)
  );

  mbx_fw_state u_fw (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (uc_state_we),
    .wdata   (uc_state_wdata),
    .state_q (fw_q)
  );

  always_comb begin
    uc_irq      = bell_q && !uc_in_reset;
    uc_op_known = op_known(uc_cmd[7:0]);
  end

  // Read multiplexer, registered on the read strobe
  always_comb begin
    rd_d = '0;
    if (host_addr == A_CTRL) begin
      rd_d[CTRL_BELL] = bell_q;
      rd_d[CTRL_ERR]  = err_q;
    end
    if (host_addr == A_CMD)  rd_d = uc_cmd;
    for (int i = 0; i < NUM_PARAM; i++) begin
      if (host_addr == A_PARAM0 + ADDR_W'(i)) rd_d = uc_param[i*DATA_W +: DATA_W];
    end
    if (host_addr == A_FW)   rd_d[1:0] = fw_q;
    if (host_addr == A_STAT) rd_d[0] = uc_in_reset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_d;
  end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              bit_bell,
  input logic              uc_in_reset,
  input logic              uc_irq,
  input logic              uc_done,
  input logic              bell,
  input logic              err,
  input logic [DATA_W-1:0] cmd,
  input logic [1:0]        fw
);
  logic ctrl_wr, cmd_wr;
  assign ctrl_wr = host_wr && (host_addr == ADDR_W'(mbx_pkg::OFS_CTRL));
  assign cmd_wr  = host_wr && (host_addr == ADDR_W'(mbx_pkg::OFS_CMD));

  // R2
  ring_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && bit_bell |=> bell);
  // R2
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bell && ctrl_wr && !bit_bell && !uc_done |=> bell);
  // R3
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uc_done && !(ctrl_wr && bit_bell) |=> !bell);
  // R4
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uc_in_reset |-> !uc_irq);
  // R4
  irq_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bell && !uc_in_reset |-> uc_irq);
  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bell && cmd_wr |=> $stable(cmd));
  // R6
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bell && cmd_wr |=> err);
  // R8
  fw_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw != 2'd3);
endmodule

bind mbx_host_mailbox mbx_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_addr   (host_addr),
  .host_wr     (host_wr),
  .bit_bell    (host_wdata[0]),
  .uc_in_reset (uc_in_reset),
  .uc_irq      (uc_irq),
  .uc_done     (uc_done),
  .bell        (bell_q),
  .err         (err_q),
  .cmd         (uc_cmd),
  .fw          (fw_q)
);

// File: tb/mbx_host_mailbox_tb_top.sv
module mbx_host_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        uc_in_reset = 1'b0;
  logic        uc_irq, uc_op_known;
  logic [31:0] uc_cmd;
  logic [95:0] uc_param;
  logic        uc_done = 1'b0, uc_state_we = 1'b0;
  logic [1:0]  uc_state_wdata = '0;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  mbx_host_mailbox dut_i (.*);

  // Behavioural reference
  logic        m_bell, m_err;
  logic [31:0] m_cmd, m_rd;
  logic [31:0] m_par [3];
  logic [1:0]  m_fw;

  function automatic logic ref_known(input logic [7:0] op);
    return op inside {8'h20, 8'h21, 8'h23, 8'h31, 8'h6A, 8'h88, 8'h89, 8'h90, 8'h91};
  endfunction

  function automatic logic [31:0] ref_read(input logic [3:0] a);
    case (a)
      4'd0: return {30'd0, m_err, m_bell};
      4'd1: return m_cmd;
      4'd2, 4'd3, 4'd4: return m_par[a-2];
      4'd5: return {30'd0, m_fw};
      4'd6: return {31'd0, uc_in_reset};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bell = 0; m_err = 0; m_cmd = 0; m_rd = 0; m_fw = 0;
      foreach (m_par[k]) m_par[k] = 0;
    end else begin
      logic data_wr;
      if (host_rd) m_rd = ref_read(host_addr);
      data_wr = host_wr && host_addr >= 1 && host_addr <= 4;
      if (data_wr && m_bell) m_err = 1;
      else if (data_wr) begin
        if (host_addr == 1) m_cmd = host_wdata;
        else m_par[host_addr-2] = host_wdata;
      end else if (host_wr && host_addr == 0 && host_wdata[1]) m_err = 0;
      if (host_wr && host_addr == 0 && host_wdata[0]) m_bell = 1;
      else if (uc_done) m_bell = 0;
      if (uc_state_we && uc_state_wdata != 2'd3) m_fw = uc_state_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Every-cycle comparison, one ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R4 irq", {31'd0, uc_irq}, {31'd0, m_bell && !uc_in_reset});
      chk("R5 cmd", uc_cmd, m_cmd);
      chk("R5 param", uc_param, {m_par[2], m_par[1], m_par[0]});
      chk("R7 opcode flag", {31'd0, uc_op_known}, {31'd0, ref_known(m_cmd[7:0])});
      chk("R10 rdata", host_rdata, m_rd);
    end
  end

  task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); uc_done = 1;
    @(negedge clk); uc_done = 0;
  endtask

  task automatic set_fw(input logic [1:0] v);
    @(negedge clk); uc_state_we = 1; uc_state_wdata = v;
    @(negedge clk); uc_state_we = 0;
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL R1 watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    hread(0, v); chk("R1 ctrl", v, 0);
    hread(1, v); chk("R1 cmd", v, 0);
    hread(3, v); chk("R1 param1", v, 0);
    hread(5, v); chk("R1 fw", v, 0);
    chk("R1 irq", {31'd0, uc_irq}, 0);
    // R5 load
    hwrite(2, 32'h1111_0000); hwrite(3, 32'h2222_0001); hwrite(4, 32'h3333_0002);
    hwrite(1, 32'h0000_0023);
    hread(1, v); chk("R5 cmd read", v, 32'h23);
    hread(4, v); chk("R5 param2 read", v, 32'h3333_0002);
    chk("R5 param port", uc_param, {32'h3333_0002, 32'h2222_0001, 32'h1111_0000});
    // R2 ring
    hwrite(0, 1);
    chk("R4 irq after ring", {31'd0, uc_irq}, 1);
    hread(0, v); chk("R2 ring", v, 1);
    hwrite(0, 0);
    hread(0, v); chk("R2 zero write", v, 1);
    // R6 blocked writes
    hwrite(1, 32'h55); hwrite(2, 32'hDEAD);
    hread(1, v); chk("R6 cmd kept", v, 32'h23);
    hread(2, v); chk("R6 param kept", v, 32'h1111_0000);
    hread(0, v); chk("R6 err set", v, 3);
    hwrite(0, 2);
    hread(0, v); chk("R6 err cleared", v, 1);
    // R4 / R9 reset pin
    @(negedge clk); uc_in_reset = 1;
    @(negedge clk); chk("R4 irq masked", {31'd0, uc_irq}, 0);
    hread(6, v); chk("R9 status set", v, 1);
    @(negedge clk); uc_in_reset = 0;
    hread(6, v); chk("R9 status clear", v, 0);
    // R3 completion
    pulse_done();
    hread(0, v); chk("R3 done clears", v, 0);
    chk("R3 irq low", {31'd0, uc_irq}, 0);
    @(negedge clk); host_wr = 1; host_addr = 0; host_wdata = 1; uc_done = 1;
    @(negedge clk); host_wr = 0; uc_done = 0;
    hread(0, v); chk("R3 ring beats done", v, 1);
    pulse_done();
    // R7 opcode set
    foreach (m_par[k]) begin end
    begin
      logic [7:0] ops [12] = '{8'h20, 8'h21, 8'h23, 8'h31, 8'h6A, 8'h88,
                               8'h89, 8'h90, 8'h91, 8'h22, 8'h00, 8'hFF};
      for (int i = 0; i < 12; i++) begin
        hwrite(1, {24'hABCDEF, ops[i]});
        chk("R7 opcode", {31'd0, uc_op_known}, {31'd0, i < 9});
      end
    end
    // R8 firmware state
    set_fw(1); hread(5, v); chk("R8 loaded", v, 1);
    set_fw(3); hread(5, v); chk("R8 illegal ignored", v, 1);
    hwrite(5, 2); hread(5, v); chk("R8 host write ignored", v, 1);
    set_fw(2); hread(5, v); chk("R8 running", v, 2);
    // R10 undefined addresses
    hread(9, v); chk("R10 undefined 9", v, 0);
    hread(15, v); chk("R10 undefined 15", v, 0);
    // Random traffic checked against the reference every clock
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      host_wr = ($urandom % 3) == 0;
      host_rd = ($urandom % 2) == 0;
      host_addr = 4'($urandom % 8);
      host_wdata = $urandom;
      uc_done = ($urandom % 6) == 0;
      uc_state_we = ($urandom % 10) == 0;
      uc_state_wdata = 2'($urandom);
      if (($urandom % 40) == 0) uc_in_reset = ~uc_in_reset;
    end
    @(negedge clk);
    host_wr = 0; host_rd = 0; uc_done = 0; uc_state_we = 0;
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule